// File: doc/BRIEF.md
# Multicycle Issue Hazard Guard

This block sits at the decode/issue stage of an in-order pipeline whose execution units finish after different fixed numbers of cycles. Each cycle it looks at the instruction waiting in decode: which unit it needs, which registers it reads and which register it writes. From that it decides whether the instruction may leave decode this cycle or must be held there.

The guard keeps three kinds of state. The first is a slot map of future cycles in which the single register-file write port is already claimed. The second is a busy counter for the divider, which is not pipelined. The third is a per-register countdown giving the number of cycles left before each outstanding destination is written. Integer and floating-point registers carry separate countdowns. An instruction that stalls leaves all three untouched. The guard does not forward operands, handle exceptions or model the units' datapaths.

Top module: `mc_issue_guard`

## Requirements
- R1: After reset no write, destination or divide is outstanding, so the first valid instruction of any class issues in its first cycle.
- R2: `id_issue` is high exactly when `id_valid` is high and no hazard exists, and `id_stall` is high exactly when `id_valid` is high and a hazard exists. With `id_valid` low, both outputs are low.
- R3: Unit codes on `id_unit` are 0 integer ALU (latency 1), 1 memory (latency 2), 2 FP add (latency 4), 3 FP multiply (latency 7) and 4 FP divide (latency 25). Codes 5 to 7 behave as the ALU. An instruction issued in cycle t writes back in cycle t+latency.
- R4: After a divide issues in cycle t, another divide stalls in cycles t+1 to t+24 and may issue in cycle t+25.
- R5: The ALU, memory, FP add and FP multiply units accept an independent instruction every cycle.
- R6: An instruction with `id_dst_en` high stalls if its write-back cycle is already claimed by an issued instruction. An instruction with `id_dst_en` low neither claims nor checks the write port.
- R7: An instruction stalls while any enabled source has a write outstanding. It issues in the cycle in which that write-back occurs.
- R8: An instruction stalls if an issued instruction still has to write the same destination in the same cycle as it or later (WAW).
- R9: Register tags are 6 bits: bit 5 selects the file (1 = floating point) and bits 4:0 the index. Equal indices in different files never conflict.
- R10: A stalled instruction claims no write slot, no destination and no divider time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | An instruction is present in decode |
| id_unit | input | 3 | Execution unit code |
| id_src_a | input | 6 | First source register tag |
| id_src_b | input | 6 | Second source register tag |
| id_src_en | input | 2 | Bit 0 enables source A, bit 1 enables source B |
| id_dst | input | 6 | Destination register tag |
| id_dst_en | input | 1 | The instruction writes `id_dst` |
| id_issue | output | 1 | The instruction leaves decode this cycle |
| id_stall | output | 1 | The instruction is held in decode this cycle |

## Verification
A WAW hold and a write-port collision can apply to the same cycle. The bench provokes this by issuing a divide to an FP register and then holding an FP add to that same register right behind it. In the add's twenty-first stall cycle, its write-back would land on the divide's write-back cycle while the divide is still outstanding, so both causes are active at once. The bench judges this by counting: the add must stall exactly 21 cycles and issue in the first cycle in which both causes have cleared.

// File: rtl/mc_issue_pkg.sv
package mc_issue_pkg;

    typedef enum logic [2:0] {
        UNIT_ALU  = 3'd0,
        UNIT_MEM  = 3'd1,
        UNIT_FADD = 3'd2,
        UNIT_FMUL = 3'd3,
        UNIT_FDIV = 3'd4
    } unit_e;

    localparam int TAG_W = 6;
    localparam int NREG  = 1 << TAG_W;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mc_wport_slots.sv
module mc_wport_slots #(
    parameter int LEN   = 26,
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic             wr_en,
    input  logic [LAT_W-1:0] lat,
    output logic             taken
);

    typedef struct packed {
        logic [LEN-1:0] slots;
    } slot_st_t;

    slot_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.slots = st_q.slots >> 1;
        if (commit && wr_en) begin
            st_d.slots[lat - 1'b1] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign taken = st_q.slots[lat];

    AST_WPORT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && wr_en) |-> !st_q.slots[lat]); // R6

endmodule

// File: rtl/mc_dst_board.sv
module mc_dst_board #(
    parameter int NREG  = 64,
    parameter int TAG_W = 6,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [TAG_W-1:0] src_a,
    input  logic [TAG_W-1:0] src_b,
    input  logic [1:0]       src_en,
    input  logic [TAG_W-1:0] dst,
    input  logic             dst_en,
    input  logic [CNT_W-1:0] lat,
    output logic             raw_hit,
    output logic             waw_hit
);

    typedef struct packed {
        logic [NREG-1:0][CNT_W-1:0] left;
    } board_st_t;

    board_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            st_d.left[i] = (st_q.left[i] != '0) ? st_q.left[i] - 1'b1 : '0;
        end
        if (commit && dst_en) begin
            st_d.left[dst] = lat - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_hit = (src_en[0] && (st_q.left[src_a] != '0)) ||
                     (src_en[1] && (st_q.left[src_b] != '0));
    assign waw_hit = dst_en && (st_q.left[dst] >= lat);

    AST_SRC_READY_A: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && src_en[0]) |-> (st_q.left[src_a] == '0)); // R7
    AST_SRC_READY_B: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && src_en[1]) |-> (st_q.left[src_b] == '0)); // R7
    AST_WAW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && dst_en) |-> (st_q.left[dst] < lat)); // R8

endmodule

// File: rtl/mc_div_gate.sv
module mc_div_gate #(
    parameter int II = 25,
    parameter int W  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit_div,
    output logic busy
);

    typedef struct packed {
        logic [W-1:0] wait_cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit_div)                 st_d.wait_cnt = W'(II - 1);
        else if (st_q.wait_cnt != '0)   st_d.wait_cnt = st_q.wait_cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.wait_cnt != '0);

    AST_DIV_IDLE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        commit_div |-> (st_q.wait_cnt == '0)); // R4

endmodule

// File: rtl/mc_issue_guard.sv
module mc_issue_guard
    import mc_issue_pkg::*;
#(
    parameter int LAT_ALU  = 1,
    parameter int LAT_MEM  = 2,
    parameter int LAT_FADD = 4,
    parameter int LAT_FMUL = 7,
    parameter int LAT_FDIV = 25,
    parameter int DIV_II   = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_valid,
    input  logic [2:0]       id_unit,
    input  logic [TAG_W-1:0] id_src_a,
    input  logic [TAG_W-1:0] id_src_b,
    input  logic [1:0]       id_src_en,
    input  logic [TAG_W-1:0] id_dst,
    input  logic             id_dst_en,
    output logic             id_issue,
    output logic             id_stall
);

    localparam int MAX_LAT  = max2(max2(max2(LAT_ALU, LAT_MEM), max2(LAT_FADD, LAT_FMUL)), LAT_FDIV);
    localparam int SLOT_LEN = MAX_LAT + 1;
    localparam int LAT_W    = $clog2(SLOT_LEN);
    localparam int DIV_W    = $clog2(DIV_II + 1);

    logic [LAT_W-1:0] lat;
    logic             is_div;
    logic             port_taken, port_hit, raw_hit, waw_hit, div_busy, hazard;

    always_comb begin
        is_div = 1'b0;
        case (id_unit)
            UNIT_MEM:  lat = LAT_W'(LAT_MEM);
            UNIT_FADD: lat = LAT_W'(LAT_FADD);
            UNIT_FMUL: lat = LAT_W'(LAT_FMUL);
            UNIT_FDIV: begin
                lat    = LAT_W'(LAT_FDIV);
                is_div = 1'b1;
            end
            default:   lat = LAT_W'(LAT_ALU);
        endcase
    end

    assign port_hit = id_dst_en && port_taken;
    assign hazard   = port_hit || raw_hit || waw_hit || (is_div && div_busy);
    assign id_issue = id_valid && !hazard;
    assign id_stall = id_valid && hazard;

    mc_wport_slots #(.LEN(SLOT_LEN), .LAT_W(LAT_W)) u_slots (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (id_issue),
        .wr_en  (id_dst_en),
        .lat    (lat),
        .taken  (port_taken)
    );

    mc_dst_board #(.NREG(NREG), .TAG_W(TAG_W), .CNT_W(LAT_W)) u_board (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (id_issue),
        .src_a   (id_src_a),
        .src_b   (id_src_b),
        .src_en  (id_src_en),
        .dst     (id_dst),
        .dst_en  (id_dst_en),
        .lat     (lat),
        .raw_hit (raw_hit),
        .waw_hit (waw_hit)
    );

    mc_div_gate #(.II(DIV_II), .W(DIV_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_div (id_issue && is_div),
        .busy       (div_busy)
    );

    AST_ISSUE_STALL_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (id_issue != id_stall) == id_valid); // R2
    AST_NO_DIV_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (id_issue && id_unit == UNIT_FDIV) |=> !(id_issue && id_unit == UNIT_FDIV)); // R4

endmodule

// File: tb/mc_issue_guard_bench.sv
`timescale 1ns/1ps
module mc_issue_guard_bench;

    localparam logic [2:0] U_ALU = 3'd0, U_MEM = 3'd1, U_FADD = 3'd2, U_FMUL = 3'd3, U_FDIV = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       id_valid = 1'b0;
    logic [2:0] id_unit = '0;
    logic [5:0] id_src_a = '0, id_src_b = '0, id_dst = '0;
    logic [1:0] id_src_en = '0;
    logic       id_dst_en = 1'b0;
    logic       id_issue, id_stall;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mc_issue_guard u_mc_issue_guard (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_unit(id_unit),
        .id_src_a(id_src_a), .id_src_b(id_src_b), .id_src_en(id_src_en),
        .id_dst(id_dst), .id_dst_en(id_dst_en), .id_issue(id_issue), .id_stall(id_stall)
    );

    function automatic logic [5:0] xr(input int n); return 6'(n);      endfunction
    function automatic logic [5:0] fr(input int n); return 6'(32 + n); endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // present one instruction until it issues, then compare stall count
    task automatic issue_one(input logic [2:0] unit, input logic [5:0] sa, input logic [5:0] sb,
                             input logic [1:0] sen, input logic [5:0] dst, input logic den,
                             input int exp, input string req);
        int stalls = 0;
        @(negedge clk);
        id_valid = 1'b1; id_unit = unit; id_src_a = sa; id_src_b = sb;
        id_src_en = sen; id_dst = dst; id_dst_en = den;
        forever begin
            #2;
            if (id_issue === 1'b1 && id_stall === 1'b0) break;
            if (id_stall !== 1'b1 || id_issue !== 1'b0) begin
                check(1'b0, {req, " stall/issue split (R2)"}, int'(id_issue), 0);
                break;
            end
            stalls++;
            if (stalls > 80) break;
            @(negedge clk);
        end
        check(stalls == exp, req, stalls, exp);
        @(posedge clk);
        #1 id_valid = 1'b0;
    endtask

    task automatic t_reset_and_idle();
        @(negedge clk); #2;
        check(id_issue === 1'b0 && id_stall === 1'b0, "R2 idle outputs low", int'(id_stall), 0);
        issue_one(U_FDIV, '0, '0, 2'b00, fr(9), 1'b1, 0, "R1 divide issues right after reset");
        idle(30);
    endtask

    task automatic t_back_to_back();
        issue_one(U_FMUL, '0, '0, 2'b00, fr(20), 1'b1, 0, "R5 fmul 1");
        issue_one(U_FMUL, '0, '0, 2'b00, fr(21), 1'b1, 0, "R5 fmul 2");
        issue_one(U_FMUL, '0, '0, 2'b00, fr(22), 1'b1, 0, "R5 fmul 3");
        issue_one(U_ALU,  '0, '0, 2'b00, xr(4),  1'b1, 0, "R5 alu 1");
        issue_one(U_ALU,  '0, '0, 2'b00, xr(5),  1'b1, 0, "R5 alu 2");
        idle(30);
    endtask

    task automatic t_raw();
        issue_one(U_FADD, '0, '0, 2'b00, fr(1), 1'b1, 0, "R7 fadd producer");
        issue_one(U_FADD, fr(2), fr(1), 2'b11, fr(6), 1'b1, 3, "R7 fadd consumer waits 3 (R3 lat 4)");
        idle(30);
        issue_one(U_MEM, '0, '0, 2'b00, xr(3), 1'b1, 0, "R7 load producer");
        issue_one(U_ALU, xr(3), '0, 2'b01, xr(7), 1'b1, 1, "R7 alu after load waits 1 (R3 lat 2)");
        idle(30);
    endtask

    task automatic t_files();
        issue_one(U_MEM, '0, '0, 2'b00, xr(3), 1'b1, 0, "R9 integer load");
        issue_one(U_FADD, fr(3), '0, 2'b01, fr(6), 1'b1, 0, "R9 FP source same index no stall");
        idle(30);
    endtask

    task automatic t_port();
        issue_one(U_FMUL, '0, '0, 2'b00, fr(10), 1'b1, 0, "R6 fmul claims slot");
        idle(2);
        issue_one(U_FADD, '0, '0, 2'b00, fr(11), 1'b1, 1, "R6 fadd write-back collision");
        idle(30);
        issue_one(U_FMUL, '0, '0, 2'b00, fr(10), 1'b1, 0, "R6 fmul claims slot again");
        idle(2);
        issue_one(U_FADD, '0, '0, 2'b00, fr(11), 1'b0, 0, "R6 no-destination op ignores port");
        idle(30);
    endtask

    task automatic t_divider();
        issue_one(U_FDIV, '0, '0, 2'b00, fr(2), 1'b1, 0, "R4 first divide");
        issue_one(U_FDIV, '0, '0, 2'b00, fr(3), 1'b1, 24, "R4 second divide waits 24");
        idle(60);
    endtask

    task automatic t_waw_and_port();
        issue_one(U_FDIV, '0, '0, 2'b00, fr(4), 1'b1, 0, "R8 long divide");
        issue_one(U_FADD, '0, '0, 2'b00, fr(4), 1'b1, 21, "R8 fadd same dest waits 21 (R6 overlaps)");
        idle(60);
    endtask

    task automatic t_stall_leaves_no_trace();
        issue_one(U_FDIV, '0, '0, 2'b00, fr(5), 1'b1, 0, "R10 divide");
        @(negedge clk);
        id_valid = 1'b1; id_unit = U_FDIV; id_dst = fr(7); id_dst_en = 1'b1; id_src_en = 2'b00;
        #2;
        check(id_stall === 1'b1, "R10 second divide held", int'(id_stall), 1);
        @(posedge clk); #1 id_valid = 1'b0;
        issue_one(U_FADD, fr(7), '0, 2'b01, fr(8), 1'b1, 0, "R10 no pending left by stalled divide");
        idle(60);
    endtask

    initial begin
        #3_000_000;
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        #1 rst_n = 1'b1;
        t_reset_and_idle();
        t_back_to_back();
        t_raw();
        t_files();
        t_port();
        t_divider();
        t_waw_and_port();
        t_stall_leaves_no_trace();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule